// File: doc/BRIEF.md
# Three-Stage Clos Path Allocator

This block is the connection-setup controller for a three-stage space switch with `N_PORTS` ports. The first stage is made of `N_PORTS/GRP` switches. Each of them has `GRP` inputs and `MIDS` outputs. The middle stage is made of `MIDS` switches. Each middle switch has one link to every first-stage switch and one link to every last-stage switch. The last stage mirrors the first. Port `p` belongs to edge switch `p / GRP` on its side of the fabric.

Software or a host sequencer issues one request at a time. A request is either a setup, which joins an input port to an output port, or a release, which frees an input port. For a setup, the allocator checks every middle switch in the same cycle. It picks the lowest-numbered one whose link from the input's edge switch and whose link to the output's edge switch are both idle, then records the path. If every middle switch is busy on at least one of the two links, the setup is reported as blocked, even when both ports are idle. When `MIDS >= 2*GRP-1` this cannot happen. The crosspoint datapath and the cell transfer are outside the block.

Top module: `clos_path_alloc`

## Requirements
- R1: After reset, every port and every middle-switch link is idle, and `rsp_valid` is low.
- R2: Each request with `req_valid` high produces exactly one response, with `rsp_valid` high, on the clock edge after the one that samples it. `rsp_valid` is low in every other cycle. Back-to-back requests see the state left by the previous one.
- R3: The op encoding is 0 for setup and 1 for release. A setup whose input and output ports are both valid and idle returns status 0 (ok) when a middle switch is free on both of its links. `rsp_mid` then carries the lowest such middle switch index, and both links of that switch become busy.
- R4: A setup of two idle, valid ports for which no middle switch is free on both links returns status 1 (blocked). It changes neither the port state nor the link state.
- R5: A setup whose input port is already connected, whose output port is already in use, or which names a port `>= N_PORTS` returns status 2 (error) and changes no state.
- R6: A release of a connected input returns status 0 with the middle switch index recorded at setup. It frees the input port, its recorded output port and both links of that path.
- R7: A release of an idle input, or of an input `>= N_PORTS`, returns status 2 and changes no state. `req_out` is ignored by a release.
- R8: When `MIDS >= 2*GRP-1`, no setup ever returns status 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_op | input | 1 | 0 = setup, 1 = release |
| req_in | input | PW | Input port number |
| req_out | input | PW | Output port number (setup only) |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_status | output | 2 | 0 ok, 1 blocked, 2 error |
| rsp_mid | output | MW | Middle switch index of the path (0 unless ok) |

## Verification
A directed sequence on the 6-port, 2-per-group, 2-middle configuration builds a state in which input 3 and output 5 are both idle but every middle switch is busy on one of their links. This tells a correct blocking report apart from a check that looks only at the ports. Releasing one path and retrying the same setup shows that a release frees both links and that the lowest free middle switch is chosen. Deliberate misuse then exercises each error case separately: a busy input, a busy output, an out-of-range port, and the release of an idle input. A seeded random mix of setups and releases, compared with a bench model, covers the selection order under many occupancy patterns. A second instance with three middle switches runs the same stimulus and must never report blocking.

// File: rtl/clos_pkg.sv
package clos_pkg;
   typedef enum logic [1:0] {
      ST_OK      = 2'd0,
      ST_BLOCKED = 2'd1,
      ST_ERROR   = 2'd2
   } clos_status_e;

   typedef enum logic {
      OP_SETUP   = 1'b0,
      OP_RELEASE = 1'b1
   } clos_op_e;
endpackage

// File: rtl/clos_link_map.sv
module clos_link_map #(
   parameter int MIDS = 2,
   parameter int NGRP = 3,
   localparam int GW = (NGRP > 1) ? $clog2(NGRP) : 1,
   localparam int MW = (MIDS > 1) ? $clog2(MIDS) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [GW-1:0]   qry_lg,
   input  logic [GW-1:0]   qry_rg,
   input  logic            upd_en,
   input  logic            upd_val,
   input  logic [MW-1:0]   upd_mid,
   input  logic [GW-1:0]   upd_lg,
   input  logic [GW-1:0]   upd_rg,
   output logic [MIDS-1:0] free_vec
);
   for (genvar m = 0; m < MIDS; m++) begin : g_mid
      logic [NGRP-1:0] busy_l;
      logic [NGRP-1:0] busy_r;
      logic            hit;

      assign hit = upd_en && (upd_mid == MW'(m));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            busy_l <= '0;
            busy_r <= '0;
         end else if (hit) begin
            busy_l[upd_lg] <= upd_val;
            busy_r[upd_rg] <= upd_val;
         end
      end

      assign free_vec[m] = !busy_l[qry_lg] && !busy_r[qry_rg];

      // R3: a link is never booked twice
      a_r3_no_double_book: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && upd_val) |-> (!busy_l[upd_lg] && !busy_r[upd_rg]));
      // R6: a release only clears links that were held
      a_r6_clear_held: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && !upd_val) |-> (busy_l[upd_lg] && busy_r[upd_rg]));
   end
endmodule

// File: rtl/clos_pick.sv
module clos_pick #(
   parameter int W = 2,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end
   assign found = |vec;
endmodule

// File: rtl/clos_path_table.sv
module clos_path_table #(
   parameter int NP   = 6,
   parameter int MIDS = 2,
   localparam int PW = (NP > 1) ? $clog2(NP) : 1,
   localparam int MW = (MIDS > 1) ? $clog2(MIDS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_en,
   input  logic          clr_en,
   input  logic [PW-1:0] wr_in,
   input  logic [PW-1:0] wr_out,
   input  logic [MW-1:0] wr_mid,
   input  logic [PW-1:0] rd_in,
   output logic [PW-1:0] rd_dest,
   output logic [MW-1:0] rd_mid,
   output logic [NP-1:0] conn_vec,
   output logic [NP-1:0] obusy_vec
);
   logic [PW-1:0] dest_q [NP];
   logic [MW-1:0] mid_q  [NP];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         conn_vec  <= '0;
         obusy_vec <= '0;
         for (int i = 0; i < NP; i++) begin
            dest_q[i] <= '0;
            mid_q[i]  <= '0;
         end
      end else if (set_en) begin
         conn_vec[wr_in]   <= 1'b1;
         obusy_vec[wr_out] <= 1'b1;
         dest_q[wr_in]     <= wr_out;
         mid_q[wr_in]      <= wr_mid;
      end else if (clr_en) begin
         conn_vec[wr_in]          <= 1'b0;
         obusy_vec[dest_q[wr_in]] <= 1'b0;
      end
   end

   assign rd_dest = dest_q[rd_in];
   assign rd_mid  = mid_q[rd_in];

   // R6: every connected input owns exactly one busy output
   a_r6_port_balance: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(conn_vec) == $countones(obusy_vec));
   // R5: a setup never lands on a busy port
   a_r5_set_idle: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |-> (!conn_vec[wr_in] && !obusy_vec[wr_out]));
endmodule

// File: rtl/clos_path_alloc.sv
module clos_path_alloc
   import clos_pkg::*;
#(
   parameter int N_PORTS = 6,
   parameter int GRP     = 2,
   parameter int MIDS    = 2,
   localparam int PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
   localparam int MW = (MIDS > 1) ? $clog2(MIDS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_op,
   input  logic [PW-1:0] req_in,
   input  logic [PW-1:0] req_out,
   output logic          rsp_valid,
   output logic [1:0]    rsp_status,
   output logic [MW-1:0] rsp_mid
);
   localparam int NGRP = N_PORTS / GRP;
   localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1;

   if (GRP < 1 || MIDS < 1 || N_PORTS < 2) begin : g_bad_size
      $error("clos_path_alloc: sizes must be positive");
   end
   if (N_PORTS % GRP != 0) begin : g_bad_split
      $error("clos_path_alloc: N_PORTS must be a multiple of GRP");
   end

   logic          in_ok, out_ok;
   logic [PW-1:0] in_idx, out_idx;
   logic [GW-1:0] in_grp, out_grp, rel_grp;
   logic [PW-1:0] rd_dest;
   logic [MW-1:0] rd_mid;
   logic [N_PORTS-1:0] conn_vec, obusy_vec;
   logic [MIDS-1:0] free_vec;
   logic            found;
   logic [MW-1:0]   pick_idx;

   logic          tbl_set, tbl_clr;
   logic          lnk_en, lnk_val;
   logic [MW-1:0] lnk_mid;
   logic [GW-1:0] lnk_rg;
   clos_status_e  st_n;
   logic [MW-1:0] mid_n;

   assign in_ok   = int'(req_in) < N_PORTS;
   assign out_ok  = int'(req_out) < N_PORTS;
   assign in_idx  = in_ok ? req_in : '0;
   assign out_idx = out_ok ? req_out : '0;
   assign in_grp  = GW'(int'(in_idx) / GRP);
   assign out_grp = GW'(int'(out_idx) / GRP);
   assign rel_grp = GW'(int'(rd_dest) / GRP);

   clos_path_table #(.NP(N_PORTS), .MIDS(MIDS)) u_table (
      .clk(clk), .rst_n(rst_n),
      .set_en(tbl_set), .clr_en(tbl_clr),
      .wr_in(in_idx), .wr_out(out_idx), .wr_mid(pick_idx),
      .rd_in(in_idx), .rd_dest(rd_dest), .rd_mid(rd_mid),
      .conn_vec(conn_vec), .obusy_vec(obusy_vec)
   );

   clos_link_map #(.MIDS(MIDS), .NGRP(NGRP)) u_links (
      .clk(clk), .rst_n(rst_n),
      .qry_lg(in_grp), .qry_rg(out_grp),
      .upd_en(lnk_en), .upd_val(lnk_val), .upd_mid(lnk_mid),
      .upd_lg(in_grp), .upd_rg(lnk_rg),
      .free_vec(free_vec)
   );

   clos_pick #(.W(MIDS)) u_pick (
      .vec(free_vec), .found(found), .idx(pick_idx)
   );

   always_comb begin
      st_n    = ST_ERROR;
      mid_n   = '0;
      tbl_set = 1'b0;
      tbl_clr = 1'b0;
      lnk_en  = 1'b0;
      lnk_val = 1'b0;
      lnk_mid = pick_idx;
      lnk_rg  = out_grp;
      if (req_valid) begin
         if (clos_op_e'(req_op) == OP_SETUP) begin
            if (!in_ok || !out_ok || conn_vec[in_idx] || obusy_vec[out_idx]) begin
               st_n = ST_ERROR;
            end else if (found) begin
               st_n    = ST_OK;
               mid_n   = pick_idx;
               tbl_set = 1'b1;
               lnk_en  = 1'b1;
               lnk_val = 1'b1;
            end else begin
               st_n = ST_BLOCKED;
            end
         end else begin
            if (!in_ok || !conn_vec[in_idx]) begin
               st_n = ST_ERROR;
            end else begin
               st_n    = ST_OK;
               mid_n   = rd_mid;
               tbl_clr = 1'b1;
               lnk_en  = 1'b1;
               lnk_mid = rd_mid;
               lnk_rg  = rel_grp;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_status <= ST_OK;
         rsp_mid    <= '0;
      end else begin
         rsp_valid  <= req_valid;
         rsp_status <= st_n;
         rsp_mid    <= mid_n;
      end
   end

   // R2: one response per request, one cycle later
   a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R4, R5, R7: a refused request leaves the port state alone
   a_r5_refuse_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status != ST_OK) |->
         (conn_vec == $past(conn_vec) && obusy_vec == $past(obusy_vec)));
   // R3: an ok index names an existing middle switch
   a_r3_mid_range: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == ST_OK) |-> (int'(rsp_mid) < MIDS));

   if (MIDS >= 2 * GRP - 1) begin : g_nonblocking
      // R8: enough middle switches means no blocking
      a_r8_never_blocked: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_valid |-> (rsp_status != ST_BLOCKED));
   end
endmodule

// File: tb/clos_path_alloc_test.sv
module clos_path_alloc_test;
   localparam int N = 6;
   localparam int G = 2;
   localparam int K = 2;
   localparam int NG = N / G;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_op = 1'b0;
   logic [2:0] req_in = '0;
   logic [2:0] req_out = '0;
   logic rsp_valid;
   logic [1:0] rsp_status;
   logic [0:0] rsp_mid;
   logic nb_valid;
   logic [1:0] nb_status;
   logic [1:0] nb_mid;

   int total = 0;
   int bad = 0;

   bit m_ic [N];
   bit m_ob [N];
   int m_dst [N];
   int m_mid [N];
   bit m_lb [K][NG];
   bit m_rb [K][NG];

   always #2.5 clk = ~clk;

   clos_path_alloc #(.N_PORTS(N), .GRP(G), .MIDS(K)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_in(req_in), .req_out(req_out),
      .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_mid(rsp_mid));

   clos_path_alloc #(.N_PORTS(N), .GRP(G), .MIDS(3)) uut_nb (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_in(req_in), .req_out(req_out),
      .rsp_valid(nb_valid), .rsp_status(nb_status), .rsp_mid(nb_mid));

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // expected outcome from the requirements; updates the model state
   task automatic model(input bit op, input int i, input int o,
                        output int st, output int md);
      st = 2;
      md = 0;
      if (op == 1'b0) begin
         if (i < N && o < N && !m_ic[i] && !m_ob[o]) begin
            st = 1;
            for (int m = K - 1; m >= 0; m--)
               if (!m_lb[m][i / G] && !m_rb[m][o / G]) begin
                  st = 0;
                  md = m;
               end
            if (st == 0) begin
               m_ic[i] = 1'b1; m_ob[o] = 1'b1; m_dst[i] = o; m_mid[i] = md;
               m_lb[md][i / G] = 1'b1; m_rb[md][o / G] = 1'b1;
            end
         end
      end else if (i < N && m_ic[i]) begin
         st = 0;
         md = m_mid[i];
         m_ic[i] = 1'b0; m_ob[m_dst[i]] = 1'b0;
         m_lb[md][i / G] = 1'b0; m_rb[md][m_dst[i] / G] = 1'b0;
      end
   endtask

   task automatic request(input bit op, input int i, input int o);
      int st, md;
      string tag;
      model(op, i, o, st, md);
      if (st == 1) tag = "R4";
      else if (st == 2) tag = op ? "R7" : "R5";
      else tag = op ? "R6" : "R3";
      @(negedge clk);
      req_valid = 1'b1;
      req_op = op;
      req_in = 3'(i);
      req_out = 3'(o);
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid == 1'b1, "R2", "rsp_valid", int'(rsp_valid), 1);
      chk(int'(rsp_status) == st, tag, "status", int'(rsp_status), st);
      if (st == 0) chk(int'(rsp_mid) == md, tag, "mid", int'(rsp_mid), md);
      chk(nb_status != 2'd1, "R8", "nb status", int'(nb_status), 0);
   endtask

   initial begin
      #1000000;
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd17));
      repeat (3) @(negedge clk);
      chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", int'(rsp_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R1", "rsp_valid idle", int'(rsp_valid), 0);

      // R3: lowest middle first, then next free
      request(1'b0, 0, 2);
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R2", "no second response", int'(rsp_valid), 0);
      request(1'b0, 1, 4);
      request(1'b0, 2, 0);
      // R4: both ports idle yet every middle busy on one side
      request(1'b0, 3, 5);
      // R5: busy input, busy output, out of range
      request(1'b0, 0, 3);
      request(1'b0, 4, 2);
      request(1'b0, 6, 3);
      request(1'b0, 3, 6);
      // R7: idle input, out of range, req_out ignored
      request(1'b1, 5, 2);
      request(1'b1, 6, 0);
      // R6: release frees links so the blocked pair now fits via middle 1
      request(1'b1, 1, 0);
      request(1'b0, 3, 5);
      // R6: released output reusable
      request(1'b0, 4, 4);
      for (int i = 0; i < N; i++) request(1'b1, i, 0);

      for (int n = 0; n < 400; n++) begin
         bit op = ($urandom % 10) >= 6;
         int i = int'($urandom % 7);
         int o = int'($urandom % 7);
         request(op, i, o);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule